// File: doc/BRIEF.md
# Multi-user Walsh-Hadamard chip spreader

This block takes one QPSK symbol per user for a code slot and turns the whole set into one summed stream of complex chips for a multicarrier modulator. User k is spread with Walsh-Hadamard row k. The block does not multiply a code generator output per user. It loads the users' symbols into a local vector and runs an in-place fast Hadamard transform over that vector, one butterfly stage per clock. The transform result is already the sum over users, in chip order.

The spreading length is picked per slot from 4, 8, 16, 32 or 64 by a select input. That select is sampled together with the symbols when the slot is accepted. The transform of the next slot overlaps the streaming of the current one. A producer that keeps `in_valid` high therefore gets an uninterrupted stream of one chip per clock. Several data words per user fill a multicarrier symbol by offering consecutive slots. Each output chip is wider than the input by log2 of the largest length, so no sum is clipped.

Top module: `wh_spreader`

## Requirements
- R1: For a slot of length L, output chip c carries, for I and Q separately, the sum over the active users u < L of d_u, with a minus sign where the count of set bits of (u AND c) is odd. Here d_u is the user's signed input taken from bits [u*DW +: DW] of `in_re` or `in_im`.
- R2: `cfg_len_sel` picks the length: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32, 4 gives 64. The codes 5, 6 and 7 give 64.
- R3: Each accepted slot produces exactly L cycles with `out_valid` high. On those cycles `out_chip` counts 0 to L-1 in steps of one, and `out_first` is high only on chip 0.
- R4: A user whose `in_active` bit is 0 contributes nothing. Users with an index of L or more contribute nothing to a slot of length L.
- R5: When slots are offered back to back, `out_valid` stays high without a gap from the first chip of the first slot to the last chip of the last.
- R6: The length select is sampled at the acceptance edge. Changing it afterwards does not change the length or content of a slot already accepted.
- R7: After reset, `out_valid` is 0 and `in_ready` is 1.
- R8: In the cycle after an acceptance `in_ready` is 0. Data presented while `in_ready` is 0 is not taken.
- R9: Output words are DW+log2(NMAX) bits wide and exact at full scale. For example, 64 users at -128 give -8192 on chip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_sel | input | 3 | Spreading length select, sampled at acceptance |
| in_valid | input | 1 | Slot data offered |
| in_ready | output | 1 | Block can take a slot |
| in_active | input | NMAX | Per-user active mask |
| in_re | input | NMAX*DW | Signed I value per user, user u at [u*DW +: DW] |
| in_im | input | NMAX*DW | Signed Q value per user, same layout |
| out_valid | output | 1 | Chip valid |
| out_first | output | 1 | Chip 0 of a slot |
| out_chip | output | log2(NMAX) | Chip index within the slot |
| out_re | output | DW+log2(NMAX) | Summed I chip, signed |
| out_im | output | DW+log2(NMAX) | Summed Q chip, signed |

## Verification
The bench builds the block with its defaults: 8-bit inputs and a 64-entry transform. With these defaults every length from 4 to 64 can be reached at run time, along with the full six-stage growth of the word width. The short lengths leave most of the buffer unused. This shows that the upper users stay out of a short slot and that a 4-chip slot, whose compute window is tightest, still streams without gaps. The 64-user full-scale cases reach the extreme sums, and the out-of-range select codes reach the clamp to 64.

// File: rtl/whs_pkg.sv
package whs_pkg;
  localparam int SEL_W   = 3;
  localparam int MIN_LOG = 2;

  // log2 of the spreading length for a select code, clamped to the buffer
  function automatic int span_log(input logic [SEL_W-1:0] sel, input int max_log);
    int l;
    l = MIN_LOG + int'(sel);
    if (l > max_log) l = max_log;
    return l;
  endfunction
endpackage

// File: rtl/wh_load.sv
module wh_load #(
  parameter int DW   = 8,
  parameter int NMAX = 64,
  parameter int OW   = 14
) (
  input  logic [NMAX-1:0]    act,
  input  logic [NMAX*DW-1:0] re_flat,
  input  logic [NMAX*DW-1:0] im_flat,
  output logic signed [OW-1:0] re [NMAX],
  output logic signed [OW-1:0] im [NMAX]
);
  for (genvar u = 0; u < NMAX; u++) begin : g_user
    assign re[u] = act[u] ? OW'($signed(re_flat[u*DW +: DW])) : '0;
    assign im[u] = act[u] ? OW'($signed(im_flat[u*DW +: DW])) : '0;
  end
endmodule

// File: rtl/wh_stage.sv
module wh_stage #(
  parameter int NMAX = 64,
  parameter int OW   = 14,
  parameter int CW   = 3
) (
  input  logic [CW-1:0]        stg,
  input  logic signed [OW-1:0] x [NMAX],
  output logic signed [OW-1:0] y [NMAX]
);
  localparam int IW = $clog2(NMAX);

  // one radix-2 butterfly stage with span 2**stg
  for (genvar j = 0; j < NMAX; j++) begin : g_bf
    logic [IW-1:0] h;
    logic [IW-1:0] p;
    assign h = IW'(1) << stg;
    assign p = IW'(j) ^ h;
    assign y[j] = ((IW'(j) & h) != '0) ? (x[p] - x[j]) : (x[j] + x[p]);
  end
endmodule

// File: rtl/wh_outbuf.sv
module wh_outbuf #(
  parameter int NMAX = 64,
  parameter int OW   = 14,
  parameter int CW   = 3,
  localparam int LOGN = $clog2(NMAX)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CW-1:0]        load_log,
  input  logic signed [OW-1:0] load_re [NMAX],
  input  logic signed [OW-1:0] load_im [NMAX],
  output logic                 can_load,
  output logic                 out_valid,
  output logic                 out_first,
  output logic [LOGN-1:0]      out_chip,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  logic signed [OW-1:0] bre [NMAX];
  logic signed [OW-1:0] bim [NMAX];
  logic                 busy;
  logic [LOGN-1:0]      cnt;
  logic [LOGN-1:0]      lastidx;

  assign can_load = !busy || (cnt == lastidx);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      lastidx   <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_chip  <= '0;
    end else begin
      out_valid <= busy;
      out_first <= busy && (cnt == '0);
      if (busy) begin
        out_chip <= cnt;
        cnt      <= cnt + 1'b1;
        if (cnt == lastidx) busy <= 1'b0;
      end
      if (load) begin
        busy    <= 1'b1;
        cnt     <= '0;
        lastidx <= LOGN'((32'd1 << load_log) - 32'd1);
      end
    end
  end

  // data path without reset; old chip is read before the new slot lands
  always_ff @(posedge clk) begin
    out_re <= bre[cnt];
    out_im <= bim[cnt];
    if (load) begin
      bre <= load_re;
      bim <= load_im;
    end
  end
endmodule

// File: rtl/wh_spreader.sv
module wh_spreader #(
  parameter int DW   = 8,
  parameter int NMAX = 64,
  localparam int LOGN = $clog2(NMAX),
  localparam int OW   = DW + LOGN,
  localparam int CW   = $clog2(LOGN + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [whs_pkg::SEL_W-1:0]   cfg_len_sel,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NMAX-1:0]             in_active,
  input  logic [NMAX*DW-1:0]          in_re,
  input  logic [NMAX*DW-1:0]          in_im,
  output logic                        out_valid,
  output logic                        out_first,
  output logic [LOGN-1:0]             out_chip,
  output logic signed [OW-1:0]        out_re,
  output logic signed [OW-1:0]        out_im
);
  typedef enum logic [1:0] {W_IDLE, W_RUN, W_DONE} wst_t;

  wst_t                 wst;
  logic [CW-1:0]        stg;
  logic [CW-1:0]        wlog;
  logic signed [OW-1:0] wre [NMAX];
  logic signed [OW-1:0] wim [NMAX];
  logic signed [OW-1:0] ld_re [NMAX];
  logic signed [OW-1:0] ld_im [NMAX];
  logic signed [OW-1:0] st_re [NMAX];
  logic signed [OW-1:0] st_im [NMAX];
  logic                 accept;
  logic                 xfer;
  logic                 ob_can_load;

  assign in_ready = (wst == W_IDLE);
  assign accept   = in_valid && in_ready;
  assign xfer     = (wst == W_DONE) && ob_can_load;

  wh_load #(.DW(DW), .NMAX(NMAX), .OW(OW)) u_load (
    .act(in_active), .re_flat(in_re), .im_flat(in_im), .re(ld_re), .im(ld_im)
  );

  wh_stage #(.NMAX(NMAX), .OW(OW), .CW(CW)) u_stage_re (
    .stg(stg), .x(wre), .y(st_re)
  );

  wh_stage #(.NMAX(NMAX), .OW(OW), .CW(CW)) u_stage_im (
    .stg(stg), .x(wim), .y(st_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wst  <= W_IDLE;
      stg  <= '0;
      wlog <= '0;
    end else begin
      case (wst)
        W_IDLE: if (accept) begin
          wlog <= CW'(whs_pkg::span_log(cfg_len_sel, LOGN));
          stg  <= '0;
          wst  <= W_RUN;
        end
        W_RUN: begin
          stg <= stg + 1'b1;
          if (stg == wlog - 1'b1) wst <= W_DONE;
        end
        W_DONE: if (xfer) wst <= W_IDLE;
        default: wst <= W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wre <= ld_re;
      wim <= ld_im;
    end else if (wst == W_RUN) begin
      wre <= st_re;
      wim <= st_im;
    end
  end

  wh_outbuf #(.NMAX(NMAX), .OW(OW), .CW(CW)) u_obuf (
    .clk(clk), .rst(rst), .load(xfer), .load_log(wlog),
    .load_re(wre), .load_im(wim), .can_load(ob_can_load),
    .out_valid(out_valid), .out_first(out_first), .out_chip(out_chip),
    .out_re(out_re), .out_im(out_im)
  );
endmodule

// File: rtl/wh_spreader_chk.sv
module wh_spreader_chk #(
  parameter int LOGN = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_first,
  input logic [LOGN-1:0] out_chip
);
  // R7
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  // R3
  first_chip_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_first) |-> (out_chip == '0));

  // R3
  chip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> ($past(out_valid) && out_chip == $past(out_chip) + LOGN'(1)));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> (out_chip != '0));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind wh_spreader wh_spreader_chk #(.LOGN(LOGN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_first(out_first), .out_chip(out_chip)
);

// File: tb/tb_wh_spreader.sv
`timescale 1ns/1ps
module tb_wh_spreader;
  localparam int DW   = 8;
  localparam int NMAX = 64;
  localparam int LOGN = 6;
  localparam int OW   = DW + LOGN;

  typedef struct {
    int re;
    int im;
    int chip;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [2:0]           cfg_len_sel = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [NMAX-1:0]      in_active = '0;
  logic [NMAX*DW-1:0]   in_re = '0;
  logic [NMAX*DW-1:0]   in_im = '0;
  logic                 out_valid;
  logic                 out_first;
  logic [LOGN-1:0]      out_chip;
  logic signed [OW-1:0] out_re;
  logic signed [OW-1:0] out_im;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int first_t = -1;
  int last_t = -1;
  int nvalid = 0;
  int unsigned seed = 32'h1234_5678;
  exp_t expq[$];
  logic signed [DW-1:0] g_re [NMAX];
  logic signed [DW-1:0] g_im [NMAX];
  logic [NMAX-1:0] g_act;

  always #5 clk = ~clk;

  wh_spreader #(.DW(DW), .NMAX(NMAX)) dut (
    .clk(clk), .rst(rst), .cfg_len_sel(cfg_len_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_active(in_active), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_first(out_first), .out_chip(out_chip),
    .out_re(out_re), .out_im(out_im)
  );

  // monitor: pops expected chips as the design emits them
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (!rst && out_valid) begin
      nvalid++;
      if (first_t < 0) first_t = cyc;
      last_t = cyc;
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R3: chip %0d emitted, expected no chip", out_chip);
      end else begin
        e = expq.pop_front();
        if (int'(out_re) != e.re || int'(out_im) != e.im ||
            int'(out_chip) != e.chip || out_first != (e.chip == 0)) begin
          fails++;
          $display("FAIL R1/R3: chip %0d first %0b re %0d im %0d, expected chip %0d re %0d im %0d",
                   out_chip, out_first, out_re, out_im, e.chip, e.re, e.im);
        end
      end
    end
  end

  function automatic int sel_len(input logic [2:0] sel);
    return (sel > 3'd4) ? 64 : (4 << sel);
  endfunction

  function automatic logic [7:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic fill_rand(input logic [NMAX-1:0] act);
    for (int u = 0; u < NMAX; u++) begin
      g_re[u] = next_rand();
      g_im[u] = next_rand();
    end
    g_act = act;
  endtask

  task automatic check(input bit ok, input string msg, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act_v, exp_v);
    end
  endtask

  // driver: computes the expected chips by direct summation, then hands the slot over
  task automatic send_group(input logic [2:0] sel);
    int len;
    exp_t e;
    len = sel_len(sel);
    for (int c = 0; c < len; c++) begin
      e.re = 0; e.im = 0; e.chip = c;
      for (int u = 0; u < len; u++) begin
        if (g_act[u]) begin
          if (^(u & c)) begin
            e.re -= int'(g_re[u]); e.im -= int'(g_im[u]);
          end else begin
            e.re += int'(g_re[u]); e.im += int'(g_im[u]);
          end
        end
      end
      expq.push_back(e);
    end
    cfg_len_sel = sel;
    in_active   = g_act;
    for (int u = 0; u < NMAX; u++) begin
      in_re[u*DW +: DW] = g_re[u];
      in_im[u*DW +: DW] = g_im[u];
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic mark();
    first_t = -1; last_t = -1; nvalid = 0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(in_ready == 1'b1, "R7 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);

    // R1 R2 every length select, all users active
    for (int s = 0; s < 5; s++) begin
      fill_rand('1);
      send_group(3'(s));
      drain();
    end

    // R2 out-of-range select codes act as 64
    fill_rand('1);
    send_group(3'd6);
    fill_rand('1);
    send_group(3'd7);
    drain();

    // R4 inactive users and users beyond the length are excluded
    fill_rand({32'h0000_FFFF, 32'hFFFF_FF5A});
    send_group(3'd1);
    fill_rand(64'hF0F0_0000_0000_0C31);
    send_group(3'd3);
    drain();

    // R9 full-scale sums
    for (int u = 0; u < NMAX; u++) begin
      g_re[u] = -8'sd128;
      g_im[u] = 8'sd127;
    end
    g_act = '1;
    send_group(3'd4);
    for (int u = 0; u < NMAX; u++) begin
      g_re[u] = ($countones(u) % 2 == 1) ? -8'sd128 : 8'sd127;
      g_im[u] = ($countones(u) % 2 == 1) ? 8'sd127 : -8'sd128;
    end
    send_group(3'd4);
    drain();

    // R5 back-to-back slots stream without gaps (shortest and a mid length)
    mark();
    for (int k = 0; k < 6; k++) begin
      fill_rand('1);
      send_group(3'd0);
    end
    drain();
    check(nvalid == 24, "R5 chips in 4-chip burst", nvalid, 24);
    check(last_t - first_t + 1 == 24, "R5 span of 4-chip burst", last_t - first_t + 1, 24);
    mark();
    for (int k = 0; k < 4; k++) begin
      fill_rand('1);
      send_group(3'd2);
    end
    drain();
    check(nvalid == 64, "R5 chips in 16-chip burst", nvalid, 64);
    check(last_t - first_t + 1 == 64, "R5 span of 16-chip burst", last_t - first_t + 1, 64);

    // R6 select changed right after acceptance; mixed lengths back to back
    mark();
    fill_rand('1);
    send_group(3'd2);
    cfg_len_sel = 3'd0;
    idle(4);
    cfg_len_sel = 3'd4;
    drain();
    check(nvalid == 16, "R6 slot length kept after select change", nvalid, 16);
    fill_rand('1);
    send_group(3'd3);
    fill_rand('1);
    send_group(3'd0);
    fill_rand('1);
    send_group(3'd4);
    drain();

    // R8 junk shown while in_ready is low is not taken
    fill_rand('1);
    send_group(3'd4);
    check(in_ready == 1'b0, "R8 in_ready after acceptance", int'(in_ready), 0);
    for (int u = 0; u < NMAX; u++) begin
      in_re[u*DW +: DW] = 8'h7F;
      in_im[u*DW +: DW] = 8'h80;
    end
    cfg_len_sel = 3'd0;
    in_valid = 1'b1;
    @(negedge clk);
    fill_rand('1);
    send_group(3'd1);
    mark();
    drain();
    check(nvalid == 72, "R8 chips after junk offer", nvalid, 72);
    check(expq.size() == 0, "R3 leftover expected chips", expq.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: %0d chips outstanding, expected 0", expq.size());
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule